// File: doc/BRIEF.md
# Serial LFSR Check-Bit Register

This block is an internal-XOR linear feedback shift register that divides a serial bit stream by a generator polynomial. One bit arrives on each enabled clock, highest-degree bit first. The incoming bit is XORed with the top stage and the result loads stage 0. The top stage also drives an XOR gate in front of every stage whose polynomial term is present. After the last bit the register holds the remainder of the stream divided by the polynomial. This remainder is read in parallel from the register output.

A message padded with N zero bits leaves the N check bits in the register. Sending the message followed by those check bits leaves zero. If one bit is flipped, the register holds a nonzero syndrome that tells the position of the flipped bit. With the serial input held at zero the same register runs as a pseudo-random sequence generator. A single 1 bit sent into a cleared register seeds it. Framing the stream, appending the zero bits and storing the message are left to the surrounding logic.

Top module: `lfsr_check_gen`

## Requirements
- R1: A high `rst` at a rising clock edge clears `check_q` to zero, whatever `shift_en` and `ser_in` are.
- R2: When `shift_en` is low (and `rst` low), `check_q` keeps its value at the edge, whatever `ser_in` is.
- R3: On an enabled edge, bit 0 loads `check_q[N-1] ^ ser_in`. Bit K (0<K<N) loads `check_q[K-1] ^ check_q[N-1]` when bit K of the tap mask `TAPS` is 1, and `check_q[K-1]` otherwise. Bit K of `TAPS` stands for the term x^K; x^N and x^0 are implied. For example, with N=5 and TAPS=5'b00100 a state of 5'b10000 steps to 5'b00101. With the default polynomial a state of 8'h80 steps to 8'h1D.
- R4: The defaults are N=8 and TAPS=8'b0001_1100, which gives x^8+x^4+x^3+x^2+1. After a cleared register receives a message followed by N zero bits, `check_q` equals the message polynomial times x^N modulo the generator. These are the check bits.
- R5: A cleared register that receives a message and then its check bits (bit N-1 of the check word first) ends at zero.
- R6: If one bit of that message-plus-check stream is inverted at position i, counted from the stream end with the last bit as i=0, the final `check_q` equals x^i modulo the generator. This value is nonzero.
- R7: With `ser_in` held at 0 and a primitive polynomial, a nonzero state never steps to zero. Seeded with 1, the register visits all 2^N-1 nonzero states before it returns to 1.
- R8: A zero state with `ser_in` at 0 stays zero on enabled edges.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high clear |
| shift_en | input | 1 | Advance the register by one bit when high |
| ser_in | input | 1 | Serial stream bit, highest degree first |
| check_q | output | N | Register contents: check bits, syndrome or sequence value |

## Verification
The bench builds two copies of the block from the same stimulus. One uses the default 8-bit polynomial with three inner taps. The other uses a 5-bit polynomial with a single tap at stage 2. The 8-bit copy is used for check-bit generation, the zero remainder of a coded stream, and syndromes for errors near both ends of a 24-bit stream. It also covers a full 255-state free-running period. The 5-bit copy shows that the tap mask really selects the XOR positions. Its 31-state period ends inside the same free-running run, so both period lengths are checked against distinct primitive polynomials.

// File: rtl/lfsr_pkg.sv
package lfsr_pkg;
  // default register width and tap mask for x^8 + x^4 + x^3 + x^2 + 1
  localparam int unsigned DEF_WIDTH = 8;
  localparam logic [63:0] DEF_TAPS  = 64'h0000_0000_0000_001C;

  // role of a stage inside the register
  typedef enum logic [1:0] {
    STG_HEAD  = 2'd0,
    STG_PLAIN = 2'd1,
    STG_TAP   = 2'd2
  } stage_kind_e;

  function automatic stage_kind_e kind_of(input int unsigned idx, input logic tap_bit);
    if (idx == 0)  return STG_HEAD;
    else if (tap_bit) return STG_TAP;
    else return STG_PLAIN;
  endfunction
endpackage

// File: rtl/lfsr_feedback.sv
module lfsr_feedback (
  input  logic msb_i,
  input  logic din_i,
  output logic head_o,
  output logic tap_o
);
  // stage 0 gets the incoming bit folded into the wrap-around
  assign head_o = msb_i ^ din_i;
  // inner XOR gates see only the top stage
  assign tap_o  = msb_i;
endmodule

// File: rtl/lfsr_stage.sv
module lfsr_stage
  import lfsr_pkg::*;
#(
  parameter stage_kind_e KIND = STG_PLAIN
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic prev_i,
  input  logic fb_i,
  output logic q_o
);
  logic d;

  generate
    if (KIND == STG_TAP) begin : g_xor
      assign d = prev_i ^ fb_i;
    end else begin : g_pass
      assign d = prev_i;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)     q_o <= 1'b0;
    else if (en) q_o <= d;
  end
endmodule

// File: rtl/lfsr_check_gen.sv
module lfsr_check_gen
  import lfsr_pkg::*;
#(
  parameter int unsigned N    = DEF_WIDTH,
  parameter logic [N-1:0] TAPS = DEF_TAPS[N-1:0]
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         shift_en,
  input  logic         ser_in,
  output logic [N-1:0] check_q
);
  localparam int unsigned TOP = N - 1;

  logic [N-1:0] st;
  logic         head_fb;
  logic         tap_fb;

  lfsr_feedback u_fb (
    .msb_i  (st[TOP]),
    .din_i  (ser_in),
    .head_o (head_fb),
    .tap_o  (tap_fb)
  );

  for (genvar k = 0; k < N; k++) begin : g_stage
    localparam stage_kind_e KIND_K = kind_of(k, TAPS[k]);
    logic prev;
    if (k == 0) begin : g_head
      assign prev = head_fb;
    end else begin : g_body
      assign prev = st[k-1];
    end
    lfsr_stage #(.KIND(KIND_K)) u_stage (
      .clk    (clk),
      .rst    (rst),
      .en     (shift_en),
      .prev_i (prev),
      .fb_i   (tap_fb),
      .q_o    (st[k])
    );
  end

  assign check_q = st;
endmodule

// File: rtl/lfsr_check_gen_chk.sv
module lfsr_check_gen_chk #(
  parameter int unsigned N    = 8,
  parameter logic [N-1:0] TAPS = '0
) (
  input logic         clk,
  input logic         rst,
  input logic         shift_en,
  input logic         ser_in,
  input logic [N-1:0] check_q
);
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !shift_en |=> $stable(check_q)); // R2

  AST_HEAD_LOAD: assert property (@(posedge clk) disable iff (rst)
    shift_en |=> check_q[0] == $past(check_q[N-1] ^ ser_in)); // R3

  for (genvar k = 1; k < N; k++) begin : g_inner
    if (TAPS[k]) begin : g_t
      AST_TAP_STAGE: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> check_q[k] == $past(check_q[k-1] ^ check_q[N-1])); // R3
    end else begin : g_p
      AST_PLAIN_STAGE: assert property (@(posedge clk) disable iff (rst)
        shift_en |=> check_q[k] == $past(check_q[k-1])); // R3
    end
  end

  AST_ZERO_FIXED: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !ser_in && check_q == '0) |=> check_q == '0); // R8

  AST_NONZERO_KEPT: assert property (@(posedge clk) disable iff (rst)
    (shift_en && !ser_in && check_q != '0) |=> check_q != '0); // R7
endmodule

bind lfsr_check_gen lfsr_check_gen_chk #(.N(N), .TAPS(TAPS)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .shift_en (shift_en),
  .ser_in   (ser_in),
  .check_q  (check_q)
);

// File: tb/tb_lfsr_check_gen.sv
module tb_lfsr_check_gen;
  localparam int CLK_PERIOD = 10;
  localparam int POLY8 = 'h11D;
  localparam int POLY5 = 'h25;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic shift_en = 1'b0;
  logic ser_in = 1'b0;
  logic [7:0] q8;
  logic [4:0] q5;

  int checks = 0;
  int failures = 0;
  int m8 = 0;
  int m5 = 0;
  string cur_req = "R1";
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lfsr_check_gen dut (
    .clk(clk), .rst(rst), .shift_en(shift_en), .ser_in(ser_in), .check_q(q8));

  lfsr_check_gen #(.N(5), .TAPS(5'b00100)) dut_small (
    .clk(clk), .rst(rst), .shift_en(shift_en), .ser_in(ser_in), .check_q(q5));

  // polynomial long division, one bit at a time
  function automatic int model_step(input int s, input int b, input int n, input int poly);
    int t;
    t = (s << 1) | (b & 1);
    if (((t >> n) & 1) != 0) t = t ^ poly;
    return t & ((1 << n) - 1);
  endfunction

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got %0h expected %0h at %0t", req, got, exp, $time);
    end
  endtask

  task automatic tick(input logic r, input logic e, input logic d);
    rst = r; shift_en = e; ser_in = d;
    @(posedge clk);
    if (r) begin m8 = 0; m5 = 0; end
    else if (e) begin
      m8 = model_step(m8, int'(d), 8, POLY8);
      m5 = model_step(m5, int'(d), 5, POLY5);
    end
    @(negedge clk);
    check({cur_req, " per-cycle N=8"}, int'(q8), m8);
    check({cur_req, " per-cycle N=5"}, int'(q5), m5);
  endtask

  task automatic send_bits(input logic [31:0] w, input int len);
    for (int i = len - 1; i >= 0; i--) tick(1'b0, 1'b1, w[i]);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [15:0] msg;
    int cbits;
    int syn;
    int ret5;
    bit seen [0:255];
    msg = 16'hB5C3;

    // R1: reset dominates enable and data
    cur_req = "R1";
    tick(1'b1, 1'b1, 1'b1);
    tick(1'b1, 1'b1, 1'b1);
    check("R1 reset clears N=8", int'(q8), 0);
    check("R1 reset clears N=5", int'(q5), 0);
    send_bits(32'h0000_00A7, 8);
    tick(1'b1, 1'b1, 1'b0);
    check("R1 reset after load", int'(q8), 0);

    // R8: zero state is a fixed point
    cur_req = "R8";
    send_bits(32'h0, 10);
    check("R8 zero stays zero", int'(q8), 0);

    // R3: single-step tap placement
    cur_req = "R3";
    tick(1'b1, 1'b0, 1'b0);
    send_bits(32'h1, 1);
    send_bits(32'h0, 4);
    check("R3 N=5 state x^4", int'(q5), 'h10);
    send_bits(32'h0, 1);
    check("R3 N=5 x^4 steps to 00101", int'(q5), 'h05);
    tick(1'b1, 1'b0, 1'b0);
    send_bits(32'h1, 1);
    send_bits(32'h0, 7);
    check("R3 N=8 state 80", int'(q8), 'h80);
    send_bits(32'h0, 1);
    check("R3 N=8 80 steps to 1D", int'(q8), 'h1D);

    // R2: hold while disabled, input toggling
    cur_req = "R2";
    for (int i = 0; i < 6; i++) tick(1'b0, 1'b0, logic'(i[0]));
    check("R2 hold N=8", int'(q8), 'h1D);

    // R4: check bits of message plus N zeros
    cur_req = "R4";
    tick(1'b1, 1'b0, 1'b0);
    send_bits({16'h0, msg}, 16);
    send_bits(32'h0, 8);
    cbits = m8;
    check("R4 check bits", int'(q8), cbits);

    // R5: message then check bits gives zero
    cur_req = "R5";
    tick(1'b1, 1'b0, 1'b0);
    send_bits({8'h0, msg, cbits[7:0]}, 24);
    check("R5 coded stream remainder", int'(q8), 0);

    // R6: single-bit errors at several positions
    cur_req = "R6";
    foreach (syn_pos[j]) begin end
    for (int k = 0; k < 5; k++) begin
      int pos;
      logic [31:0] w;
      pos = (k == 0) ? 0 : (k == 1) ? 3 : (k == 2) ? 7 : (k == 3) ? 12 : 23;
      w = {8'h0, msg, cbits[7:0]};
      w[pos] = ~w[pos];
      tick(1'b1, 1'b0, 1'b0);
      send_bits(w, 24);
      syn = 1;
      for (int s = 0; s < pos; s++) syn = model_step(syn, 0, 8, POLY8);
      check("R6 syndrome value", int'(q8), syn);
      check("R6 syndrome nonzero", int'(q8 != 8'h0), 1);
    end

    // R7: full free-running period on both widths
    cur_req = "R7";
    tick(1'b1, 1'b0, 1'b0);
    send_bits(32'h1, 1);
    foreach (seen[i]) seen[i] = 1'b0;
    seen[1] = 1'b1;
    ret5 = 0;
    for (int step = 1; step <= 255; step++) begin
      tick(1'b0, 1'b1, 1'b0);
      check("R7 never zero", int'(q8 != 8'h0), 1);
      if (ret5 == 0 && q5 == 5'd1) ret5 = step;
      if (step < 255) begin
        check("R7 new state", int'(seen[q8]), 0);
        seen[q8] = 1'b1;
      end
    end
    check("R7 N=8 period returns to 1", int'(q8), 1);
    check("R7 N=5 period 31", ret5, 31);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  int syn_pos [1];
endmodule